// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side controller of a byte-wide NOR flash array. It watches a simple write bus (address, data, write strobe) and recognises the multi-write command sequences that start a byte program, an erase of one or more sectors, or an erase of the whole array. Each command begins with two unlock writes at fixed addresses. Any write that breaks a sequence returns the decoder to plain read mode.

While an operation runs, the ready output is held low and reads return a status byte instead of array data. That byte carries the complement of bit 7 of the byte being programmed, plus a bit that flips on every status read. The array is a small stand-in memory: sector-select bits at the top of the address and a few byte-offset bits at the bottom. The address bits in between alias. Down-counters set how long each operation lasts.

During a sector erase, sectors that are not being erased stay usable: they can still be read, and programs aimed at them still complete. The reset input abandons any pending operation and puts the decoder back in read mode.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A program takes four writes: AAh at address bits [14:0] = 5555h, then 55h at 2AAAh, then A0h at 5555h, then the data byte at the target. When it completes, the target reads as its old value AND the written byte. An erased byte reads FFh.
- R2: `ready` falls in the cycle after the fourth program write and stays low for exactly PGM_CYC clock cycles.
- R3: While a program is pending, a read of any address returns a status byte: bit 7 is the complement of data bit 7, bit 6 is the toggle bit, and bits 5:0 are zero. The toggle bit is 0 after reset and inverts after each status read.
- R4: A sector erase takes six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address in the sector. The sector is address bits [ADDR_W-1 -: SECT_W]. Afterwards every byte of the selected sectors reads FFh, and other sectors keep their contents.
- R5: After a 30h write, an accept window of WIN_CYC cycles opens. Each further 30h write in the window adds its sector and restarts the window. The erase phase of SERS_CYC cycles begins when the window expires.
- R6: A chip erase uses the first five erase writes followed by 10h@5555h. It holds `ready` low for exactly CHIP_CYC cycles and then leaves every byte at FFh.
- R7: While a sector erase is pending, a read of a selected sector returns a status byte with bit 7 = 0 and bit 6 = toggle. A read of any other sector returns array data. Once the window has closed, a program to a non-selected sector takes effect at once, and a program to a selected sector is dropped.
- R8: A write that does not match the next expected step of a sequence returns the decoder to read mode and leaves the array unchanged. A following correct sequence works normally.
- R9: Asserting `rst_n` low abandons a pending program or a half-entered sequence without changing the array, and raises `ready`.
- R10: After reset, `ready` is 1 and `rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset to read mode |
| we | input | 1 | Write strobe, one write per cycle |
| re | input | 1 | Read strobe; `rdata` is valid the cycle after |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status byte |
| ready | output | 1 | High when no program or erase is pending |

## Verification
If the sequence state is wrong, a correct command does nothing or a broken one takes effect. Either shows up on the first read of the target after the expected busy time, or at once through `ready` not falling in the cycle after the final write. A miscounted operation timer moves the rising edge of `ready` by whole cycles, so the bench measures busy length in exact cycles. If the per-sector erase mask is wrong, it shows up on the next read of a neighbouring sector: either a status byte where data was expected, or data surviving where FFh was expected. A toggle bit stuck at one value is exposed by any two successive status reads.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W   = 16,
  parameter int SECT_W   = 5,
  parameter int OFF_W    = 5,
  parameter int PGM_CYC  = 16,
  parameter int WIN_CYC  = 8,
  parameter int SERS_CYC = 64,
  parameter int CHIP_CYC = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ready
);
  localparam int NSECT = 1 << SECT_W;
  localparam int SBYTES = 1 << OFF_W;
  localparam int IDX_W = SECT_W + OFF_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(PGM_CYC + WIN_CYC + SERS_CYC + CHIP_CYC + 1);

  typedef enum logic [2:0] {C_IDLE, C_U1, C_U2, C_PGM, C_E1, C_E2, C_E3} cmd_t;
  typedef enum logic [1:0] {O_NONE, O_PGM, O_WIN, O_ERS} op_t;

  logic [7:0]       mem [DEPTH];
  cmd_t             cst;
  op_t              ost;
  logic [CNT_W-1:0] cnt;
  logic [NSECT-1:0] mask;
  logic [IDX_W-1:0] pidx;
  logic [7:0]       pdata;
  logic             tog;

  wire              at_5555 = addr[14:0] == 15'h5555;
  wire              at_2aaa = addr[14:0] == 15'h2AAA;
  wire [SECT_W-1:0] sect    = addr[ADDR_W-1 -: SECT_W];
  wire [IDX_W-1:0]  idx     = {sect, addr[OFF_W-1:0]};
  wire              erasing = (ost == O_WIN) || (ost == O_ERS);
  wire              dec_live = (ost == O_NONE) || (ost == O_ERS);
  wire              cnt_zero = cnt == '0;

  wire wr_prog    = we && dec_live && (cst == C_PGM);
  wire prog_start = wr_prog && (ost == O_NONE);
  wire prog_now   = wr_prog && (ost == O_ERS) && !mask[sect];
  wire e3_wr      = we && (ost == O_NONE) && (cst == C_E3);
  wire chip_start = e3_wr && at_5555 && (wdata == 8'h10);
  wire sec_start  = e3_wr && (wdata == 8'h30);
  wire win_add    = we && (ost == O_WIN) && (wdata == 8'h30);
  wire pgm_done   = (ost == O_PGM) && cnt_zero;
  wire ers_done   = (ost == O_ERS) && cnt_zero;
  wire status_rd  = re && !we && ((ost == O_PGM) || (erasing && mask[sect]));

  wire pgm_busy = ost == O_PGM;
  wire pgm_arm  = cst == C_PGM;

  assign ready = ost == O_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cst <= C_IDLE;
    else if (!dec_live) cst <= C_IDLE;
    else if (we) begin
      case (cst)
        C_IDLE: cst <= (at_5555 && wdata == 8'hAA) ? C_U1 : C_IDLE;
        C_U1:   cst <= (at_2aaa && wdata == 8'h55) ? C_U2 : C_IDLE;
        C_U2:
          if (at_5555 && wdata == 8'hA0) cst <= C_PGM;
          else if (at_5555 && wdata == 8'h80 && ost == O_NONE) cst <= C_E1;
          else cst <= C_IDLE;
        C_E1:   cst <= (at_5555 && wdata == 8'hAA) ? C_E2 : C_IDLE;
        C_E2:   cst <= (at_2aaa && wdata == 8'h55) ? C_E3 : C_IDLE;
        default: cst <= C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ost <= O_NONE; cnt <= '0; mask <= '0; pidx <= '0; pdata <= '0;
    end else begin
      case (ost)
        O_NONE:
          if (prog_start) begin
            ost <= O_PGM; cnt <= CNT_W'(PGM_CYC - 1); pidx <= idx; pdata <= wdata;
          end else if (chip_start) begin
            ost <= O_ERS; cnt <= CNT_W'(CHIP_CYC - 1); mask <= '1;
          end else if (sec_start) begin
            ost <= O_WIN; cnt <= CNT_W'(WIN_CYC - 1); mask <= NSECT'(1) << sect;
          end
        O_PGM:
          if (cnt_zero) ost <= O_NONE;
          else cnt <= cnt - 1'b1;
        O_WIN:
          if (win_add) begin
            mask <= mask | (NSECT'(1) << sect); cnt <= CNT_W'(WIN_CYC - 1);
          end else if (cnt_zero) begin
            ost <= O_ERS; cnt <= CNT_W'(SERS_CYC - 1);
          end else cnt <= cnt - 1'b1;
        default:
          if (cnt_zero) begin
            ost <= O_NONE; mask <= '0;
          end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ers_done)
      for (int s = 0; s < NSECT; s++)
        if (mask[s])
          for (int o = 0; o < SBYTES; o++) mem[s*SBYTES + o] <= 8'hFF;
    if (pgm_done) mem[pidx] <= mem[pidx] & pdata;
    if (prog_now) mem[idx] <= mem[idx] & wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; tog <= 1'b0;
    end else if (re && !we) begin
      if (status_rd) begin
        rdata <= {pgm_busy ? ~pdata[7] : 1'b0, tog, 6'b0};
        tog   <= ~tog;
      end else rdata <= mem[idx];
    end
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
  parameter int CNT_W = 8,
  parameter int NSECT = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic             re,
  input logic             ready,
  input logic [7:0]       rdata,
  input logic             pgm_busy,
  input logic             pgm_arm,
  input logic             status_rd,
  input logic [7:0]       pdata,
  input logic [CNT_W-1:0] cnt,
  input logic [NSECT-1:0] mask
);
  assert_pgm_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && pgm_arm && ready) |=> (!ready && pgm_busy));

  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(cnt) == '0));

  assert_status_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !we && pgm_busy) |=> ((rdata[7] == ~pdata[7]) && (rdata[5:0] == 6'b0)));

  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && $past(status_rd)) |=> (rdata[6] != $past(rdata[6])));

  assert_idle_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mask == '0));

  assert_erase_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask != '0) |-> !ready);
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.CNT_W(CNT_W), .NSECT(NSECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .re(re), .ready(ready), .rdata(rdata),
  .pgm_busy(pgm_busy), .pgm_arm(pgm_arm), .status_rd(status_rd),
  .pdata(pdata), .cnt(cnt), .mask(mask)
);

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb;
  localparam int PGM = 6, WIN = 5, SERS = 40, CHIP = 20;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        ready;
  int checks = 0, fails = 0;
  bit tog_m = 1'b0, pend = 1'b0, done = 1'b0;
  logic [7:0] qv[$];
  string      qt[$];

  always #10 clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(16), .SECT_W(5), .OFF_W(5), .PGM_CYC(PGM),
    .WIN_CYC(WIN), .SERS_CYC(SERS), .CHIP_CYC(CHIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready));

  function automatic logic [15:0] ad(input logic [4:0] s, input logic [4:0] o);
    return {s, 6'b0, o};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; re = 1'b1; qv.push_back(e); qt.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic rd_stat(input logic [15:0] a, input logic b7, input string tag);
    rd(a, {b7, tog_m, 6'b0}, tag);
    tog_m = ~tog_m;
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; tog_m = 1'b0;
  endtask

  always @(posedge clk) pend <= re && !we;

  initial forever begin
    @(negedge clk);
    if (pend) begin
      if (qv.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard actual=%h expected=none", rdata);
      end else chk(rdata, qv.pop_front(), qt.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({7'b0, ready}, 8'h01, "R10 ready after reset");
    chk(rdata, 8'h00, "R10 rdata after reset");

    erase_pre(); wr(16'h5555, 8'h10);
    chk({7'b0, ready}, 8'h00, "R6 ready low in chip erase");
    wait_ready(n);
    chk(8'(n), 8'(CHIP), "R6 chip erase busy cycles");
    rd(ad(0, 0), 8'hFF, "R6 erased s0");
    rd(ad(17, 9), 8'hFF, "R6 erased s17");
    rd(ad(31, 31), 8'hFF, "R6 erased s31");

    prog(ad(1, 3), 8'h5A);
    rd_stat(ad(1, 3), 1'b1, "R3 status during program");
    rd_stat(ad(7, 2), 1'b1, "R3 status toggled");
    wait_ready(n);
    rd(ad(1, 3), 8'h5A, "R1 programmed byte");
    prog(ad(1, 3), 8'h0F); wait_ready(n);
    rd(ad(1, 3), 8'h0A, "R1 program ANDs old value");

    prog(ad(2, 0), 8'h80);
    wait_ready(n);
    chk(8'(n), 8'(PGM), "R2 program busy cycles");
    prog(ad(2, 1), 8'h80);
    rd_stat(ad(2, 1), 1'b0, "R3 status bit7 complement of 1");
    wait_ready(n);
    rd(ad(2, 1), 8'h80, "R1 second program");

    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h66); wr(16'h5555, 8'hA0); wr(ad(4, 4), 8'h00);
    chk({7'b0, ready}, 8'h01, "R8 bad data leaves ready high");
    rd(ad(4, 4), 8'hFF, "R8 bad data no change");
    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(ad(4, 4), 8'h00);
    rd(ad(4, 4), 8'hFF, "R8 bad address no change");
    prog(ad(4, 4), 8'h33); wait_ready(n);
    rd(ad(4, 4), 8'h33, "R8 recovery program");

    erase_pre(); wr(ad(1, 0), 8'h30);
    wr(ad(3, 7), 8'h30);
    chk({7'b0, ready}, 8'h00, "R4 ready low in sector erase");
    repeat (WIN + 1) @(negedge clk);
    rd_stat(ad(1, 3), 1'b0, "R7 status in erasing sector");
    rd(ad(2, 0), 8'h80, "R7 data from other sector");
    prog(ad(2, 5), 8'h3C);
    rd(ad(2, 5), 8'h3C, "R7 program beside erase");
    prog(ad(3, 1), 8'h00);
    wait_ready(n);
    rd(ad(1, 3), 8'hFF, "R4 sector erased");
    rd(ad(3, 1), 8'hFF, "R5 added sector erased, R7 program dropped");
    rd(ad(2, 0), 8'h80, "R4 other sector kept");
    rd(ad(4, 4), 8'h33, "R4 other sector kept 2");

    prog(ad(6, 6), 8'h00);
    do_reset();
    chk({7'b0, ready}, 8'h01, "R9 ready after abort");
    rd(ad(6, 6), 8'hFF, "R9 program abandoned");
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    do_reset();
    wr(16'h5555, 8'hA0); wr(ad(6, 6), 8'h00);
    rd(ad(6, 6), 8'hFF, "R9 sequence abandoned");
    chk({7'b0, ready}, 8'h01, "R9 ready stays high");

    repeat (3) @(negedge clk);
    if (qv.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", qv.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule